// File: doc/BRIEF.md
# UART FIFO Service Request Generator

This block decides when a UART with separate receive and transmit FIFOs needs service. It reads the occupancy counts of both FIFOs, compares each against a programmable threshold and drives one level-type request per direction. A mode select for each direction routes that request to an interrupt line or to a DMA request line, or suppresses it. The FIFO storage, the serializer and deserializer, the baud generator and the register decode are outside this block and only provide it with counts, strobes and configuration.

The receive side also watches for a stalled stream. If the receive FIFO holds fewer characters than its threshold and no character arrives for three word times, a timeout raises the receive request so that software or DMA can drain the partial FIFO. The word time comes from the configured character length and is counted in oversampling ticks. When the FIFOs are switched off, each direction behaves like a single holding register: the receive side asks for service while it holds a character, and the transmit side asks for service while it is empty.

Top module: `uart_irq_gen`

## Requirements
- R1: While `rst_n` is low, all four request outputs are low. Every output is registered and follows its inputs one clock later.
- R2: With `fifo_en`=1, the transmit request is active while `tx_count` is less than or equal to the transmit threshold. The threshold for `tx_trig` 0/1/2/3 is 0/4/8/12 entries.
- R3: With `fifo_en`=1, the receive request is active while `rx_count` is greater than or equal to the receive threshold. The threshold for `rx_trig` 0/1/2/3 is 1/4/8/12 entries.
- R4: With `fifo_en`=1 and `rx_count` nonzero, the receive request becomes active once 3 word times of `tick` pulses pass without a character or a read. A word time is (5 + `word_len` + 2) × 16 ticks: 336 ticks in total for `word_len`=0 and 480 for `word_len`=3.
- R5: A pulse on `rx_strobe` or `rx_read`, an empty receive FIFO, or `fifo_en`=0 restarts the timeout count. An empty receive FIFO never raises a receive request.
- R6: With `fifo_en`=0, the thresholds are ignored. The receive request is active while `rx_count` is nonzero, and the transmit request is active while `tx_count` is zero.
- R7: A mode of 2'b01 routes a direction's request to its interrupt output. A mode of 2'b10 or 2'b11 routes it to its DMA output. A mode of 2'b00 keeps both outputs of that direction low. The interrupt and DMA outputs of one direction are never both high.
- R8: Requests are levels. An expired timeout keeps the receive request high until the timeout count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding register mode |
| rx_mode | input | 2 | Receive routing: 00 off, 01 interrupt, 1x DMA |
| tx_mode | input | 2 | Transmit routing: 00 off, 01 interrupt, 1x DMA |
| rx_trig | input | 2 | Receive threshold select |
| tx_trig | input | 2 | Transmit threshold select |
| word_len | input | 2 | Data bits minus 5 |
| tick | input | 1 | Oversampling tick, 16 per bit |
| rx_strobe | input | 1 | One-cycle pulse per received character |
| rx_read | input | 1 | One-cycle pulse per receive FIFO read |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench checks the occupancy values on each side of every threshold. Comparing with the wrong inequality, or mapping the receive select 0 to zero entries, shows up as a request that is one entry early or one entry late. It checks the timeout window for both the shortest and the longest word length, samples one cycle before and one cycle after expiry, and restarts the count with a read partway through. A limit that ignores the word length, or a counter that misses the restart, moves the edge. It also checks that an empty FIFO never times out, that the holding-register mode ignores the thresholds, and that the DMA and off modes route the request correctly.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_DMA  = 2'b10,
    MODE_DMA2 = 2'b11
  } req_mode_e;

  // ticks in the whole timeout window for a given character length
  function automatic int unsigned timeout_ticks(input logic [1:0] wl,
                                                input int unsigned ticks_per_bit,
                                                input int unsigned min_bits,
                                                input int unsigned words);
    // start bit + data bits + one stop bit
    return words * ticks_per_bit * (min_bits + 2 + int'(wl));
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter bit          IS_TX      = 1'b0,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned STEP      = FIFO_DEPTH / 4
) (
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] count,
  output logic          hit
);

  logic [CW-1:0] level;

  generate
    if (IS_TX) begin : g_tx
      // transmit: ask for data while at or below the threshold
      always_comb begin
        level = CW'(trig_sel) * CW'(STEP);
        if (fifo_en) hit = (count <= level);
        else         hit = (count == '0);
      end
    end else begin : g_rx
      // receive: ask for draining once the threshold is reached
      always_comb begin
        if (trig_sel == 2'b00) level = CW'(1);
        else                   level = CW'(trig_sel) * CW'(STEP);
        if (fifo_en) hit = (count >= level);
        else         hit = (count != '0);
      end
    end
  endgenerate

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned MIN_BITS      = 5,
  parameter int unsigned TO_WORDS      = 3,
  localparam int unsigned CW           = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned MAX_LIM      = TO_WORDS * TICKS_PER_BIT * (MIN_BITS + 3 + 2),
  localparam int unsigned LW           = $clog2(MAX_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          tick,
  input  logic          rx_strobe,
  input  logic          rx_read,
  input  logic [1:0]    word_len,
  input  logic [CW-1:0] rx_count,
  output logic          expired
);

  logic [LW-1:0] cnt_q, cnt_d, limit;
  logic          restart, cnt_en;

  assign limit   = LW'(timeout_ticks(word_len, TICKS_PER_BIT, MIN_BITS, TO_WORDS));
  assign restart = !fifo_en || rx_strobe || rx_read || (rx_count == '0);
  assign cnt_en  = restart || (tick && (cnt_q < limit));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = fifo_en && (rx_count != '0) && (cnt_q >= limit);

endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route (
  input  logic [1:0] mode,
  input  logic       req,
  output logic       irq,
  output logic       dma
);

  assign irq = req && (mode == 2'b01);
  assign dma = req && mode[1];

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned MIN_BITS      = 5,
  parameter int unsigned TO_WORDS      = 3,
  localparam int unsigned CW           = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    rx_mode,
  input  logic [1:0]    tx_mode,
  input  logic [1:0]    rx_trig,
  input  logic [1:0]    tx_trig,
  input  logic [1:0]    word_len,
  input  logic          tick,
  input  logic          rx_strobe,
  input  logic          rx_read,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_irq,
  output logic          rx_dma_req,
  output logic          tx_irq,
  output logic          tx_dma_req
);

  logic rx_hit, tx_hit, rx_to, rx_req;
  logic [3:0] req_d, req_q;

  uart_irq_trig #(.FIFO_DEPTH(FIFO_DEPTH), .IS_TX(1'b0)) u_rx_trig (
    .fifo_en (fifo_en),
    .trig_sel(rx_trig),
    .count   (rx_count),
    .hit     (rx_hit)
  );

  uart_irq_trig #(.FIFO_DEPTH(FIFO_DEPTH), .IS_TX(1'b1)) u_tx_trig (
    .fifo_en (fifo_en),
    .trig_sel(tx_trig),
    .count   (tx_count),
    .hit     (tx_hit)
  );

  uart_irq_timeout #(
    .FIFO_DEPTH   (FIFO_DEPTH),
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .MIN_BITS     (MIN_BITS),
    .TO_WORDS     (TO_WORDS)
  ) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .tick     (tick),
    .rx_strobe(rx_strobe),
    .rx_read  (rx_read),
    .word_len (word_len),
    .rx_count (rx_count),
    .expired  (rx_to)
  );

  assign rx_req = rx_hit || rx_to;

  uart_irq_route u_rx_route (
    .mode(rx_mode),
    .req (rx_req),
    .irq (req_d[3]),
    .dma (req_d[2])
  );

  uart_irq_route u_tx_route (
    .mode(tx_mode),
    .req (tx_hit),
    .irq (req_d[1]),
    .dma (req_d[0])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign {rx_irq, rx_dma_req, tx_irq, tx_dma_req} = req_q;

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic [1:0]    rx_mode,
  input logic [1:0]    tx_mode,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_irq,
  input logic          rx_dma_req,
  input logic          tx_irq,
  input logic          tx_dma_req
);

  // R7: one direction never requests on both lines
  p_excl_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq && rx_dma_req));
  p_excl_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_irq && tx_dma_req));

  // R7: mode off silences the direction
  p_off_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rx_mode) == 2'b00) |-> (!rx_irq && !rx_dma_req));

  // R2: a transmit FIFO above the highest threshold never asks for data
  p_tx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fifo_en) && $past(tx_count) > CW'(12))
      |-> (!tx_irq && !tx_dma_req));

  // R3: at or above the highest threshold the receive interrupt is up
  p_rx_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fifo_en) && $past(rx_mode) == 2'b01 && $past(rx_count) >= CW'(12))
      |-> rx_irq);

  // R5: an empty receive FIFO never raises a request
  p_rx_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rx_count) == '0) |-> (!rx_irq && !rx_dma_req));

  // R6: empty holding register asks for transmit data
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fifo_en) && $past(tx_count) == '0 && $past(tx_mode) == 2'b01)
      |-> tx_irq);

  // R1: outputs low during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rx_irq && !rx_dma_req && !tx_irq && !tx_dma_req);
    end
  end

endmodule

bind uart_irq_gen uart_irq_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_en   (fifo_en),
  .rx_mode   (rx_mode),
  .tx_mode   (tx_mode),
  .rx_count  (rx_count),
  .tx_count  (tx_count),
  .rx_irq    (rx_irq),
  .rx_dma_req(rx_dma_req),
  .tx_irq    (tx_irq),
  .tx_dma_req(tx_dma_req)
);

// File: tb/uart_irq_gen_tb.sv
`timescale 1ns/1ps
module uart_irq_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic [1:0] rx_mode, tx_mode, rx_trig, tx_trig, word_len;
  logic       tick, rx_strobe, rx_read;
  logic [4:0] rx_count, tx_count;
  logic       rx_irq, rx_dma_req, tx_irq, tx_dma_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .rx_mode(rx_mode), .tx_mode(tx_mode), .rx_trig(rx_trig), .tx_trig(tx_trig),
    .word_len(word_len), .tick(tick), .rx_strobe(rx_strobe), .rx_read(rx_read),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_irq(rx_irq), .rx_dma_req(rx_dma_req), .tx_irq(tx_irq), .tx_dma_req(tx_dma_req)
  );

  // {fifo_en, rx_mode, tx_mode, rx_trig, tx_trig, rx_count, tx_count,
  //  expected {rx_irq, rx_dma_req, tx_irq, tx_dma_req}}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 2'b01, 2'b01, 2'b00, 2'b00, 5'd0,  5'd0,  4'b0010}, // R2 R3 lowest thresholds
    {1'b1, 2'b01, 2'b01, 2'b00, 2'b00, 5'd1,  5'd1,  4'b1000}, // R2 R3
    {1'b1, 2'b01, 2'b01, 2'b01, 2'b01, 5'd3,  5'd4,  4'b0010}, // R2 R3 at 4
    {1'b1, 2'b01, 2'b01, 2'b01, 2'b01, 5'd4,  5'd5,  4'b1000}, // R2 R3
    {1'b1, 2'b01, 2'b01, 2'b10, 2'b10, 5'd7,  5'd8,  4'b0010}, // R2 R3 at 8
    {1'b1, 2'b01, 2'b01, 2'b10, 2'b10, 5'd8,  5'd9,  4'b1000}, // R2 R3
    {1'b1, 2'b01, 2'b01, 2'b11, 2'b11, 5'd11, 5'd12, 4'b0010}, // R2 R3 at 12
    {1'b1, 2'b01, 2'b01, 2'b11, 2'b11, 5'd16, 5'd13, 4'b1000}, // R2 R3
    {1'b1, 2'b10, 2'b10, 2'b01, 2'b01, 5'd5,  5'd2,  4'b0101}, // R7 DMA
    {1'b1, 2'b11, 2'b11, 2'b01, 2'b01, 5'd2,  5'd9,  4'b0000}, // R7 DMA, no hit
    {1'b1, 2'b00, 2'b00, 2'b00, 2'b11, 5'd16, 5'd0,  4'b0000}, // R7 off
    {1'b1, 2'b01, 2'b10, 2'b00, 2'b00, 5'd1,  5'd0,  4'b1001}, // R7 mixed
    {1'b0, 2'b01, 2'b01, 2'b11, 2'b00, 5'd1,  5'd0,  4'b1010}, // R6 thresholds ignored
    {1'b0, 2'b01, 2'b01, 2'b00, 2'b00, 5'd0,  5'd1,  4'b0000}, // R6
    {1'b0, 2'b10, 2'b10, 2'b00, 2'b00, 5'd1,  5'd0,  4'b0101}  // R6 R7
  };

  function automatic logic [3:0] outs();
    return {rx_irq, rx_dma_req, tx_irq, tx_dma_req};
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk) rx_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk) rx_strobe = 1'b0;
  endtask

  // measures the timeout edge starting from the current restart edge
  task automatic to_window(input string req, input int lim, input logic [3:0] hi);
    repeat (lim - 1) @(posedge clk);
    @(negedge clk) chk({req, " before expiry"}, outs(), 4'b0000);
    repeat (2) @(posedge clk);
    @(negedge clk) chk({req, " after expiry"}, outs(), hi);
  endtask

  initial begin
    rst_n = 1'b0; fifo_en = 1'b1; rx_mode = 2'b01; tx_mode = 2'b01;
    rx_trig = 2'b00; tx_trig = 2'b00; word_len = 2'b00;
    tick = 1'b0; rx_strobe = 1'b0; rx_read = 1'b0;
    rx_count = 5'd16; tx_count = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) chk("R1 reset", outs(), 4'b0000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk) chk("R1 after reset", outs(), 4'b1010);

    for (int i = 0; i < NV; i++) begin
      {fifo_en, rx_mode, tx_mode, rx_trig, tx_trig, rx_count, tx_count} = VEC[i][22:4];
      @(posedge clk);
      @(negedge clk) chk($sformatf("R2/R3/R6/R7 vector %0d", i), outs(), VEC[i][3:0]);
    end

    // R4 shortest word: 3 * 16 * 7 = 336 ticks
    fifo_en = 1'b1; rx_mode = 2'b01; tx_mode = 2'b00; rx_trig = 2'b11;
    rx_count = 5'd3; tx_count = 5'd16; word_len = 2'b00; tick = 1'b1;
    pulse_strobe();
    to_window("R4 word_len 0", 336, 4'b1000);
    // R8 stays high
    repeat (10) @(posedge clk);
    @(negedge clk) chk("R8 timeout level held", outs(), 4'b1000);
    // R5 strobe restarts
    pulse_strobe();
    @(posedge clk);
    @(negedge clk) chk("R5 strobe clears timeout", outs(), 4'b0000);

    // R4 longest word: 480 ticks, R5 read restarts partway, R7 DMA route
    rx_mode = 2'b10; word_len = 2'b11;
    pulse_strobe();
    repeat (200) @(posedge clk);
    @(negedge clk) rx_read = 1'b1;
    @(posedge clk);
    @(negedge clk) rx_read = 1'b0;
    to_window("R4 R5 R7 word_len 3 read restart", 480, 4'b0100);

    // R5 empty FIFO never times out
    rx_mode = 2'b01; rx_count = 5'd0;
    repeat (600) @(posedge clk);
    @(negedge clk) chk("R5 empty no timeout", outs(), 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule